// File: doc/BRIEF.md
# Serial Input Capture Shift Register

This block turns one general-purpose serial input into a parallel status word. An external clock divider issues a one-cycle sample strobe. On each strobe the block takes the input pin, after it has passed through a synchronizer, and writes it into the next free bit of a 28-bit capture word. Bit 0 is written first and the fill then moves upward. Once every bit holds a sample, later samples are discarded and the word stays as it is. A full flag shows that this has happened.

Software controls capture with two signals. A shift-enable level freezes capture in place when it is low. A clear pulse empties the word and moves the fill position back to bit 0. The captured word is always visible on a parallel output, so a processor can read it as a status field.

Top module: `ser_capture`

## Requirements
- R1: After reset the captured word is all zeros and the full flag is low.
- R2: The first stored sample after reset or clear goes into bit 0, and each later stored sample goes into the next higher bit. A stored bit equals the input level that was synchronized at the time of the strobe.
- R3: After 28 samples have been stored, further strobes change nothing and the word keeps its value.
- R4: A clear pulse zeroes every bit and the full flag in the next cycle. The next stored sample then goes into bit 0.
- R5: With shift enable high, every strobe stores one sample. Cycles without a strobe leave the word unchanged.
- R6: With shift enable low, strobes are ignored. Neither the contents nor the fill position change, so capture resumes at the same bit once enable returns high.
- R7: The full flag rises in the cycle after the 28th sample is stored. It stays high until a clear.
- R8: When a clear and a strobe arrive in the same cycle, the clear takes effect and the sample is not stored.
- R9: The input passes through two flip-flops before it is sampled. A strobe sees the pin level from two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial data pin, asynchronous to clk |
| sample_stb | input | 1 | One-cycle sample strobe from the clock divider |
| shift_en | input | 1 | Capture enable; low freezes the register |
| clr | input | 1 | Software clear pulse |
| cap_word | output | 28 | Captured word, bit 0 filled first |
| full | output | 1 | All 28 bits have been filled |

## Verification
The fill order is tested with three patterns. Alternating bits expose a swapped or reversed bit order. All ones show any bit that is never written. A sparse single-one pattern shows writes that land one position off. Extra strobes after the word is full are checked against a word that should not change, which separates discarding from shifting the older data out. Strobes with enable low, followed by resumed capture, show whether a frozen position is held. The strobe that collides with a clear, and a pin change placed one and two edges before a strobe, test the clear priority and the synchronizer depth.

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int WIDTH       = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             sample_stb,
  input  logic             shift_en,
  input  logic             clr,
  output logic [WIDTH-1:0] cap_word,
  output logic             full
);
  localparam int POS_W = $clog2(WIDTH + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(WIDTH);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [POS_W-1:0]       pos_q;
  logic [WIDTH-1:0]       word_q;
  logic                   din_s;
  logic                   take;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
    end else begin : g_syncn
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end
  endgenerate

  assign din_s = sync_q[SYNC_STAGES-1];
  assign take  = sample_stb & shift_en & ~clr & (pos_q != LAST);

  always_ff @(posedge clk)
    if (!rst_n || clr) pos_q <= '0;
    else if (take)     pos_q <= pos_q + 1'b1;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk)
        if (!rst_n || clr)                       word_q[i] <= 1'b0;
        else if (take && pos_q == POS_W'(i))     word_q[i] <= din_s;
    end
  endgenerate

  assign cap_word = word_q;
  assign full     = (pos_q == LAST);
endmodule

module ser_capture_chk #(
  parameter int WIDTH = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic             shift_en,
  input logic             clr,
  input logic [WIDTH-1:0] cap_word,
  input logic             full
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cap_word == '0 && !full)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(cap_word) && $stable(full)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> (full && $stable(cap_word))); // R3
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(cap_word ^ $past(cap_word)) <= 1)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !clr) |=> $stable(cap_word) && $stable(full)); // R5
  AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(sample_stb) && $past(shift_en))); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && sample_stb) |=> (cap_word == '0)); // R8
endmodule

bind ser_capture ser_capture_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .shift_en(shift_en),
  .clr(clr), .cap_word(cap_word), .full(full)
);

// File: tb/ser_capture_bench.sv
`timescale 1ns/1ps
module ser_capture_bench;
  localparam int W = 28;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         din = 1'b0;
  logic         sample_stb = 1'b0;
  logic         shift_en = 1'b1;
  logic         clr = 1'b0;
  logic [W-1:0] cap_word;
  logic         full;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_word;
  int           exp_pos;

  always #2.5 clk = ~clk;

  ser_capture u_ser_capture (
    .clk(clk), .rst_n(rst_n), .din(din), .sample_stb(sample_stb),
    .shift_en(shift_en), .clr(clr), .cap_word(cap_word), .full(full)
  );

  task automatic check(input string tag);
    checks++;
    if (cap_word !== exp_word || full !== (exp_pos == W)) begin
      errors++;
      $display("FAIL %s word=%h full=%b expected word=%h full=%b",
               tag, cap_word, full, exp_word, exp_pos == W);
    end
  endtask

  task automatic model_clear();
    exp_word = '0;
    exp_pos  = 0;
  endtask

  task automatic model_take(input logic b);
    if (shift_en && exp_pos < W) begin
      exp_word[exp_pos] = b;
      exp_pos++;
    end
  endtask

  task automatic sample(input logic b);
    @(negedge clk) din = b;
    @(negedge clk);
    @(negedge clk) sample_stb = 1'b1;
    @(negedge clk) sample_stb = 1'b0;
    model_take(b);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    model_clear();
    check("R1 reset state");
  endtask

  task automatic t_alternating();
    do_clear();
    for (int i = 0; i < 10; i++) sample(i[0]);
    check("R2 alternating fill order");
    for (int i = 0; i < 6; i++) repeat (1) @(negedge clk);
    check("R5 no strobe no change");
  endtask

  task automatic t_all_ones_full();
    do_clear();
    for (int i = 0; i < W - 1; i++) sample(1'b1);
    check("R7 full low before last bit");
    sample(1'b1);
    check("R7 full after 28th sample");
    for (int i = 0; i < 4; i++) sample(1'b0);
    check("R3 overflow samples dropped");
    repeat (5) @(negedge clk);
    check("R7 full stays high");
  endtask

  task automatic t_sparse_clear();
    do_clear();
    check("R4 clear empties word");
    for (int i = 0; i < W; i++) sample(i == 5 || i == 27);
    check("R2 sparse pattern fills exact bits");
    do_clear();
    sample(1'b1);
    check("R4 first sample after clear in bit 0");
  endtask

  task automatic t_freeze();
    do_clear();
    sample(1'b1); sample(1'b0); sample(1'b1);
    @(negedge clk) shift_en = 1'b0;
    sample(1'b1); sample(1'b1); sample(1'b1);
    check("R6 frozen while disabled");
    @(negedge clk) shift_en = 1'b1;
    sample(1'b1);
    check("R6 resumes at held position");
    for (int i = 0; i < 5; i++) sample(i[1]);
    check("R5 continuous capture when enabled");
  endtask

  task automatic t_collision();
    do_clear();
    sample(1'b1); sample(1'b1);
    @(negedge clk) din = 1'b1;
    repeat (2) @(negedge clk);
    sample_stb = 1'b1; clr = 1'b1;
    @(negedge clk) sample_stb = 1'b0; clr = 1'b0;
    model_clear();
    check("R8 clear wins over strobe");
    sample(1'b1);
    check("R8 next sample lands in bit 0");
  endtask

  task automatic t_sync_depth();
    do_clear();
    @(negedge clk) din = 1'b0;
    repeat (3) @(negedge clk);
    din = 1'b1; sample_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk) sample_stb = 1'b0;
    exp_word = '0;
    exp_word[2] = 1'b1;
    exp_pos = 3;
    check("R9 two-edge synchronizer latency");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alternating();
    t_all_ones_full();
    t_sparse_clear();
    t_freeze();
    t_collision();
    t_sync_depth();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule